// File: doc/BRIEF.md
# Time-Multiplexed Countdown Timer Bank

This block provides a large population of independent countdown timers, enough to give every software thread its own, without spending a flip-flop counter on each one. Each timer's state lives in a small per-lane memory. A free-running slot counter walks through those memories, one slot per clock cycle. In each cycle, every lane performs one read-modify-write on the entry at the current slot. With the default sizing, 32 lanes times 32 slots gives 1024 timers. Each timer is serviced once every 32 cycles, which makes one tick 32 clock cycles (0.32 µs at 100 MHz).

A processor loads a timer with a tick count, stops it by loading zero, and reads back its remaining count and running flag. When a timer runs out, its ID is queued in a small event queue. The interrupt line stays high while that queue holds anything. Software pops one ID at a time and dispatches whatever callback it associates with that timer.

Top module: `timer_bank`

## Requirements
- R1: After reset every timer reads back inactive with count 0, the interrupt is low, and the slot counter is 0.
- R2: A timer ID is {lane, slot}. Bits [4:0] select the service slot and bits [9:5] select the lane. The slot counter advances by one every cycle and wraps, so the k-th clock edge after reset release services slot (k-1) mod 32.
- R3: Loading a nonzero count N makes the timer active with count N. Each service of an active timer whose count exceeds 1 lowers the count by one. A read request returns {active, count} on rd_valid one cycle later, as held before that cycle's update.
- R4: On the N-th service after a load of N, the timer becomes inactive with count 0 and its ID is queued. The interrupt is high while the queue is non-empty. evt_id shows the oldest ID. An evt_pop removes it, and a pop of an empty queue has no effect.
- R5: Loading a count of 0 stops the timer: it reads back inactive with count 0 and never raises an event.
- R6: A load that lands in the same cycle as the service of that same entry wins: the loaded count is kept undecremented and the service write-back is dropped.
- R7: At most one ID is queued per cycle. When several lanes expire in the same slot, the lowest-numbered lane goes first. The others stay active with count 0 and are retried at their next service.
- R8: When the queue (16 entries) is full, an expiring timer stays pending (active, count 0) and is queued on a later service once there is room. No expiry is lost.
- R9: Loading a timer that is already running replaces its count, and the expiry follows the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_id | input | 10 | Timer ID to load |
| ld_count | input | 32 | Tick count to load; 0 stops the timer |
| rd_en | input | 1 | Read-back request |
| rd_id | input | 10 | Timer ID to read |
| rd_valid | output | 1 | Read-back data valid (one cycle after rd_en) |
| rd_active | output | 1 | Read-back running flag |
| rd_count | output | 32 | Read-back remaining count |
| irq | output | 1 | High while the expiry queue is non-empty |
| evt_id | output | 10 | Oldest expired timer ID |
| evt_pop | input | 1 | Remove the oldest expired ID |

## Verification
A corrupted memory entry or a slot counter that is off by one shows up at the ports as an event that arrives one slot or one tick early or late. The bench measures the edge count from load to interrupt exactly, so the error appears within a single service period of 32 cycles. A lost write-back or a collision resolved the wrong way shows in the read-back count the cycle after the next read. A faulty arbiter or a queue that overflows shows as an ID that is missing, duplicated or out of order when the queue is drained.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

  localparam int unsigned TMB_CNT_W = 32;

  typedef struct packed {
    logic                 active;
    logic [TMB_CNT_W-1:0] count;
  } tmb_entry_t;

  // Entry written by a processor load: zero means stopped.
  function automatic tmb_entry_t tmb_load(input logic [TMB_CNT_W-1:0] n);
    tmb_entry_t e;
    e.active = |n;
    e.count  = n;
    return e;
  endfunction

  // True when this service ends the countdown (or retries a pending one).
  function automatic logic tmb_due(input tmb_entry_t e);
    return e.active && (e.count <= TMB_CNT_W'(1));
  endfunction

  // Entry after one service; granted says the expiry was queued.
  function automatic tmb_entry_t tmb_step(input tmb_entry_t e, input logic granted);
    tmb_entry_t r;
    r = e;
    if (e.active) begin
      if (e.count > TMB_CNT_W'(1)) begin
        r.count = e.count - TMB_CNT_W'(1);
      end else if (granted) begin
        r = '0;
      end else begin
        r.count = '0;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tmb_phase.sv
module tmb_phase #(
  parameter int unsigned PHASES = 32,
  localparam int unsigned PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == PH_W'(PHASES - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/tmb_lane.sv
module tmb_lane
  import tmb_pkg::*;
#(
  parameter int unsigned PHASES = 32,
  localparam int unsigned PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] svc_idx,
  input  logic            ld_en,
  input  logic [PH_W-1:0] ld_idx,
  input  tmb_entry_t      ld_entry,
  input  logic [PH_W-1:0] rd_idx,
  output tmb_entry_t      rd_entry,
  output logic            due,
  input  logic            grant,
  output logic            hit
);

  tmb_entry_t mem [PHASES];
  tmb_entry_t cur;
  tmb_entry_t nxt;

  assign cur      = mem[svc_idx];
  assign hit      = ld_en && (ld_idx == svc_idx);
  assign due      = tmb_due(cur) && !hit;
  assign nxt      = tmb_step(cur, grant);
  assign rd_entry = mem[rd_idx];

  // Two write ports: the service write-back and the processor load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(PHASES); i++) begin
        mem[i] <= '0;
      end
    end else begin
      if (!hit) begin
        mem[svc_idx] <= nxt;
      end
      if (ld_en) begin
        mem[ld_idx] <= ld_entry;
      end
    end
  end

endmodule

// File: rtl/tmb_arb.sv
module tmb_arb #(
  parameter int unsigned LANES = 32,
  localparam int unsigned LN_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] req,
  input  logic             en,
  output logic [LANES-1:0] grant,
  output logic [LN_W-1:0]  idx,
  output logic             any
);

  // Scan from the top so that the lowest requesting lane is the last to win.
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = int'(LANES) - 1; i >= 0; i--) begin
      if (en && req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = LN_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmb_fifo.sv
module tmb_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 10,
  localparam int unsigned PT_W = $clog2(DEPTH),
  localparam int unsigned CT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            empty,
  output logic            full,
  output logic [CT_W-1:0] count
);

  logic [W-1:0]    store [DEPTH];
  logic [PT_W-1:0] wr_ptr;
  logic [PT_W-1:0] rd_ptr;
  logic            push_ok;
  logic            pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = store[rd_ptr];

  function automatic logic [PT_W-1:0] ptr_inc(input logic [PT_W-1:0] p);
    return (p == PT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CT_W'(push_ok) - CT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= din;
  end

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tmb_pkg::*;
#(
  parameter int unsigned LANES     = 32,
  parameter int unsigned PHASES    = 32,
  parameter int unsigned EVT_DEPTH = 16,
  localparam int unsigned PH_W = $clog2(PHASES),
  localparam int unsigned LN_W = $clog2(LANES),
  localparam int unsigned ID_W = PH_W + LN_W,
  localparam int unsigned EC_W = $clog2(EVT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [ID_W-1:0]      ld_id,
  input  logic [TMB_CNT_W-1:0] ld_count,
  input  logic                 rd_en,
  input  logic [ID_W-1:0]      rd_id,
  output logic                 rd_valid,
  output logic                 rd_active,
  output logic [TMB_CNT_W-1:0] rd_count,
  output logic                 irq,
  output logic [ID_W-1:0]      evt_id,
  input  logic                 evt_pop
);

  // Named internal events, observed by the bound checker.
  logic [PH_W-1:0]  svc_phase;
  logic [LANES-1:0] due_vec;
  logic [LANES-1:0] grant_vec;
  logic [LANES-1:0] hit_vec;
  logic [LN_W-1:0]  grant_lane;
  logic             exp_push;
  logic [ID_W-1:0]  exp_id;
  logic             fifo_full;
  logic             fifo_empty;
  logic [EC_W-1:0]  fifo_cnt;

  tmb_entry_t       ld_entry;
  tmb_entry_t       lane_rd [LANES];
  tmb_entry_t       rd_sel;
  logic [LN_W-1:0]  ld_lane;
  logic [LN_W-1:0]  rd_lane;

  assign ld_entry = tmb_load(ld_count);
  assign ld_lane  = ld_id[ID_W-1:PH_W];
  assign rd_lane  = rd_id[ID_W-1:PH_W];

  tmb_phase #(.PHASES(PHASES)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (svc_phase)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    logic ld_here;
    assign ld_here = ld_en && (ld_lane == LN_W'(g));

    tmb_lane #(.PHASES(PHASES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .svc_idx  (svc_phase),
      .ld_en    (ld_here),
      .ld_idx   (ld_id[PH_W-1:0]),
      .ld_entry (ld_entry),
      .rd_idx   (rd_id[PH_W-1:0]),
      .rd_entry (lane_rd[g]),
      .due      (due_vec[g]),
      .grant    (grant_vec[g]),
      .hit      (hit_vec[g])
    );
  end

  tmb_arb #(.LANES(LANES)) u_arb (
    .req   (due_vec),
    .en    (!fifo_full),
    .grant (grant_vec),
    .idx   (grant_lane),
    .any   (exp_push)
  );

  assign exp_id = {grant_lane, svc_phase};

  tmb_fifo #(.DEPTH(EVT_DEPTH), .W(ID_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (exp_push),
    .din   (exp_id),
    .pop   (evt_pop),
    .dout  (evt_id),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_cnt)
  );

  assign irq    = !fifo_empty;
  assign rd_sel = lane_rd[rd_lane];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_active <= 1'b0;
      rd_count  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_active <= rd_sel.active;
        rd_count  <= rd_sel.count;
      end
    end
  end

endmodule

// File: rtl/tmb_chk.sv
module tmb_chk #(
  parameter int unsigned LANES     = 32,
  parameter int unsigned PHASES    = 32,
  parameter int unsigned EVT_DEPTH = 16,
  localparam int unsigned PH_W = $clog2(PHASES),
  localparam int unsigned LN_W = $clog2(LANES),
  localparam int unsigned ID_W = PH_W + LN_W,
  localparam int unsigned EC_W = $clog2(EVT_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PH_W-1:0]  svc_phase,
  input logic [LANES-1:0] due_vec,
  input logic [LANES-1:0] grant_vec,
  input logic             exp_push,
  input logic [ID_W-1:0]  exp_id,
  input logic             fifo_full,
  input logic [EC_W-1:0]  fifo_cnt,
  input logic             irq,
  input logic             evt_pop,
  input logic             rd_en,
  input logic             rd_valid
);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (svc_phase == (($past(svc_phase) == PH_W'(PHASES - 1)) ? '0 : $past(svc_phase) + 1'b1)));

  // R2
  push_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_push |-> (exp_id[PH_W-1:0] == svc_phase));

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R7
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_push |-> ((due_vec & (grant_vec - LANES'(1))) == '0));

  // R8
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_push |-> !fifo_full);

  // R8
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= EC_W'(EVT_DEPTH));

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (fifo_cnt != '0));

  // R4
  pop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pop && irq && !exp_push) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

  // R3
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

bind timer_bank tmb_chk #(
  .LANES     (LANES),
  .PHASES    (PHASES),
  .EVT_DEPTH (EVT_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .svc_phase (svc_phase),
  .due_vec   (due_vec),
  .grant_vec (grant_vec),
  .exp_push  (exp_push),
  .exp_id    (exp_id),
  .fifo_full (fifo_full),
  .fifo_cnt  (fifo_cnt),
  .irq       (irq),
  .evt_pop   (evt_pop),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid)
);

// File: tb/tb_timer_bank.sv
module tb_timer_bank;

  localparam int SLOTS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_id = '0;
  logic [31:0] ld_count = '0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_id = '0;
  logic        rd_valid;
  logic        rd_active;
  logic [31:0] rd_count;
  logic        irq;
  logic [9:0]  evt_id;
  logic        evt_pop = 1'b0;

  int total = 0;
  int bad = 0;
  int ecount = 0;
  int ld_k = 0;

  always #2 clk = ~clk;

  // Edges since reset release; edge k services slot (k-1) mod 32 (R2).
  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  timer_bank dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_id(ld_id), .ld_count(ld_count),
    .rd_en(rd_en), .rd_id(rd_id), .rd_valid(rd_valid), .rd_active(rd_active),
    .rd_count(rd_count), .irq(irq), .evt_id(evt_id), .evt_pop(evt_pop)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic load(input int id, input int unsigned n);
    ld_k = ecount;
    ld_en = 1'b1; ld_id = 10'(id); ld_count = n;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read(input int id, output logic act, output int unsigned cnt);
    rd_en = 1'b1; rd_id = 10'(id);
    @(negedge clk);
    rd_en = 1'b0;
    act = rd_active; cnt = rd_count;
    check(rd_valid === 1'b1, "R3 rd_valid", longint'(rd_valid), 1);
  endtask

  task automatic pop();
    evt_pop = 1'b1;
    @(negedge clk);
    evt_pop = 1'b0;
  endtask

  task automatic wait_irq(input int max, output int n);
    n = 0;
    while (!irq && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_slot(input int s);
    while (ecount % SLOTS != s) @(negedge clk);
  endtask

  // Edges from the load edge to the edge that queues the expiry.
  function automatic int exp_delay(input int id, input int k, input int n);
    int d;
    d = ((id % SLOTS) - (k % SLOTS) + SLOTS) % SLOTS;
    if (d == 0) d = SLOTS;
    return d + (n - 1) * SLOTS;
  endfunction

  task automatic t_reset();
    logic a; int unsigned c;
    check(irq === 1'b0, "R1 irq", longint'(irq), 0);
    read(5, a, c);
    check(a === 1'b0, "R1 active", longint'(a), 0);
    check(c == 0, "R1 count", c, 0);
    read(1023, a, c);
    check(a === 1'b0 && c == 0, "R1 last timer", c, 0);
  endtask

  task automatic t_basic();
    int n; int e; logic a; int unsigned c;
    load(7, 3);
    e = exp_delay(7, ld_k, 3);
    wait_irq(200, n);
    check(n == e, "R4 expiry edge", n, e);
    check(evt_id == 7, "R2 R4 event id", evt_id, 7);
    read(7, a, c);
    check(a === 1'b0 && c == 0, "R4 expired entry", c, 0);
    pop();
    check(irq === 1'b0, "R4 irq cleared", longint'(irq), 0);
  endtask

  task automatic t_count();
    logic a; int unsigned c;
    load(40, 100);
    repeat (63) @(negedge clk);
    read(40, a, c);
    check(a === 1'b1, "R3 active", longint'(a), 1);
    check(c == 98, "R3 count after two ticks", c, 98);
  endtask

  task automatic t_stop();
    logic a; int unsigned c;
    load(100, 2);
    load(100, 0);
    repeat (100) @(negedge clk);
    check(irq === 1'b0, "R5 no event", longint'(irq), 0);
    read(100, a, c);
    check(a === 1'b0 && c == 0, "R5 stopped", c, 0);
    load(40, 0);
  endtask

  task automatic t_reload();
    int n; int e;
    load(3, 1000);
    repeat (5) @(negedge clk);
    load(3, 2);
    e = exp_delay(3, ld_k, 2);
    wait_irq(200, n);
    check(n == e, "R9 reload expiry edge", n, e);
    check(evt_id == 3, "R9 event id", evt_id, 3);
    pop();
  endtask

  task automatic t_collide();
    logic a; int unsigned c;
    load(10, 5);
    wait_slot(10);
    load(10, 50);
    read(10, a, c);
    check(a === 1'b1 && c == 50, "R6 load wins", c, 50);
    repeat (31) @(negedge clk);
    read(10, a, c);
    check(c == 49, "R6 next tick", c, 49);
    load(10, 0);
  endtask

  task automatic t_same_slot();
    int n; logic a; int unsigned c;
    wait_slot(20);
    load(164, 1);
    load(68, 1);
    wait_irq(100, n);
    check(evt_id == 68, "R7 lowest lane first", evt_id, 68);
    read(164, a, c);
    check(a === 1'b1 && c == 0, "R7 other pending", longint'(a), 1);
    pop();
    check(irq === 1'b0, "R7 one push per slot", longint'(irq), 0);
    wait_irq(40, n);
    check(irq === 1'b1 && evt_id == 164, "R7 retried id", evt_id, 164);
    pop();
  endtask

  task automatic t_full();
    int n; int got; int pend; logic a; int unsigned c;
    logic [17:0] seen;
    for (int i = 0; i < 18; i++) load(i, 1);
    repeat (80) @(negedge clk);
    pend = 0;
    for (int i = 0; i < 18; i++) begin
      read(i, a, c);
      if (a && c == 0) pend++;
    end
    check(pend == 2, "R8 pending while full", pend, 2);
    seen = '0; got = 0; n = 0;
    while (got < 20 && n < 400) begin
      if (irq) begin
        if (evt_id < 18 && !seen[evt_id]) seen[evt_id] = 1'b1;
        got++;
        pop();
      end else begin
        @(negedge clk);
      end
      n++;
    end
    check(got == 18, "R8 event count", got, 18);
    check(&seen, "R8 all ids once", longint'(seen), 18'h3ffff);
    pop();
    check(irq === 1'b0, "R4 pop empty", longint'(irq), 0);
    load(33, 1);
    wait_irq(40, n);
    check(irq === 1'b1 && evt_id == 33, "R4 after empty pop", evt_id, 33);
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_count();
    t_stop();
    t_reload();
    t_collide();
    t_same_slot();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule